// File: doc/BRIEF.md
# Per-Position Column Error Monitor

This block sits in a destination network interface, downstream of the error-correcting decoder. Each decoded flit arrives with an error-location vector: one bit per link wire, set where the decoder corrected a bit. The monitor keeps one small counter per wire position and adds up the corrections seen at that position over all flits of one packet. A wire with a permanent fault shows up as many errors in the same column. Transient upsets are spread across different columns.

When the last flit of a packet arrives, the monitor compares every column count with a programmable threshold. If any column is strictly above the threshold, it offers a report on a valid/ready interface. The report holds the mask of suspected positions and the packet's source and destination identifiers. Packets with no suspected position produce nothing. Only one report can be pending at a time. A further suspicious packet that ends while a report is still waiting is dropped, and a one-cycle overflow pulse marks the drop.

Top module: `colErrMonitor`

## Requirements
- R1: After reset, `rptValid` and `overflow` are low.
- R2: Within one packet, a position is suspected only when its count of set error bits is strictly greater than `threshold`. A count equal to `threshold` is not suspected. The mask bit index equals the wire position (bit i of `errVec` maps to bit i of `rptMask`).
- R3: A packet in which no position exceeds the threshold produces no report.
- R4: A report appears with `rptValid` high in the cycle after the clock edge that accepts the end-of-packet flit. It carries `srcId` and `dstId` as driven with that flit.
- R5: All counters restart from zero at a start-of-packet flit, so errors from earlier packets never contribute.
- R6: Counters are 4 bits wide and saturate at 15 instead of wrapping.
- R7: While `rptValid` is high and `rptReady` is low, `rptValid`, `rptMask`, `rptSrc` and `rptDst` stay unchanged.
- R8: If a packet with a suspected position ends while a report is pending and not being accepted, the new report is discarded and `overflow` is high for exactly the following cycle.
- R9: The threshold is taken from the `threshold` input at the end-of-packet flit. The same packet can therefore be flagged under one threshold and not under another.
- R10: A flit with both `sop` and `eop` set forms a complete one-flit packet.
- R11: Cycles with `flitValid` low do not affect the counters, whatever `errVec`, `sop` and `eop` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| threshold | input | 4 | Count that a column must exceed to be suspected |
| flitValid | input | 1 | A decoded flit is present this cycle |
| sop | input | 1 | First flit of a packet (qualified by flitValid) |
| eop | input | 1 | Last flit of a packet (qualified by flitValid) |
| errVec | input | 64 | Corrected-bit locations of the current flit |
| srcId | input | 8 | Source identifier of the packet |
| dstId | input | 8 | Destination identifier of the packet |
| rptValid | output | 1 | A report is offered |
| rptReady | input | 1 | The consumer takes the report |
| rptMask | output | 64 | Suspected positions |
| rptSrc | output | 8 | Source identifier of the reported packet |
| rptDst | output | 8 | Destination identifier of the reported packet |
| overflow | output | 1 | One-cycle pulse: a report was dropped |

## Verification
The hardest situations to reach are counter saturation and the overflow drop. Saturation needs a single packet longer than any normal protected packet, with at least sixteen errors stacked in one column. The stimulus sends a 20-flit packet that hits one column on every flit, under a threshold of 14. A wrapping counter would fall back to 4 and miss the flag. The drop needs the consumer to stall: the bench holds `rptReady` low across a first flagged packet and then completes a second flagged packet. It then checks that the first report never changed, the pulse appeared once, and the second report never came out. Idle cycles with all-ones error vectors and spurious framing bits are placed inside packets to show that unqualified cycles are ignored.

// File: rtl/colmon_pkg.sv
package colmon_pkg;
  // strobes from control to the counter bank
  typedef struct packed {
    logic clrCnt;   // restart counts with this flit
    logic accum;    // a qualified flit updates the counts
  } colmon_strobe_t;
endpackage

// File: rtl/colmon_datapath.sv
module colmon_datapath
  import colmon_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int CNT_W = 4,
  parameter int ID_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  colmon_strobe_t       strb,
  input  logic                 loadRpt,
  input  logic [WIDTH-1:0]     errVec,
  input  logic [CNT_W-1:0]     threshold,
  input  logic [ID_W-1:0]      srcId,
  input  logic [ID_W-1:0]      dstId,
  output logic                 anyHit,
  output logic [WIDTH-1:0]     rptMask,
  output logic [ID_W-1:0]      rptSrc,
  output logic [ID_W-1:0]      rptDst
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [WIDTH-1:0] hitVec;

  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;

    assign base = strb.clrCnt ? '0 : cnt;
    assign nxt  = (errVec[i] && (base != CNT_MAX)) ? base + 1'b1 : base;
    assign hitVec[i] = (nxt > threshold);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           cnt <= '0;
      else if (strb.accum) cnt <= nxt;
    end
  end

  assign anyHit = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rptMask <= '0;
      rptSrc  <= '0;
      rptDst  <= '0;
    end else if (loadRpt) begin
      rptMask <= hitVec;
      rptSrc  <= srcId;
      rptDst  <= dstId;
    end
  end
endmodule

// File: rtl/colmon_ctrl.sv
module colmon_ctrl
  import colmon_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           flitValid,
  input  logic           sop,
  input  logic           eop,
  input  logic           anyHit,
  input  logic           rptReady,
  output colmon_strobe_t strb,
  output logic           loadRpt,
  output logic           rptValid,
  output logic           overflow
);
  logic endHit;
  logic stalled;

  assign strb.accum  = flitValid;
  assign strb.clrCnt = flitValid & sop;

  assign endHit  = flitValid & eop & anyHit;
  assign stalled = rptValid & ~rptReady;
  assign loadRpt = endHit & ~stalled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rptValid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (loadRpt)       rptValid <= 1'b1;
      else if (rptReady) rptValid <= 1'b0;
      overflow <= endHit & stalled;
    end
  end
endmodule

// File: rtl/colErrMonitor.sv
module colErrMonitor
  import colmon_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int CNT_W = 4,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] threshold,
  input  logic             flitValid,
  input  logic             sop,
  input  logic             eop,
  input  logic [WIDTH-1:0] errVec,
  input  logic [ID_W-1:0]  srcId,
  input  logic [ID_W-1:0]  dstId,
  output logic             rptValid,
  input  logic             rptReady,
  output logic [WIDTH-1:0] rptMask,
  output logic [ID_W-1:0]  rptSrc,
  output logic [ID_W-1:0]  rptDst,
  output logic             overflow
);
  colmon_strobe_t strb;
  logic           loadRpt;
  logic           anyHit;

  colmon_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flitValid(flitValid),
    .sop      (sop),
    .eop      (eop),
    .anyHit   (anyHit),
    .rptReady (rptReady),
    .strb     (strb),
    .loadRpt  (loadRpt),
    .rptValid (rptValid),
    .overflow (overflow)
  );

  colmon_datapath #(.WIDTH(WIDTH), .CNT_W(CNT_W), .ID_W(ID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadRpt  (loadRpt),
    .errVec   (errVec),
    .threshold(threshold),
    .srcId    (srcId),
    .dstId    (dstId),
    .anyHit   (anyHit),
    .rptMask  (rptMask),
    .rptSrc   (rptSrc),
    .rptDst   (rptDst)
  );
endmodule

// File: rtl/colmon_checker.sv
module colmon_checker #(
  parameter int WIDTH = 64,
  parameter int ID_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             flitValid,
  input logic             eop,
  input logic             rptValid,
  input logic             rptReady,
  input logic [WIDTH-1:0] rptMask,
  input logic [ID_W-1:0]  rptSrc,
  input logic [ID_W-1:0]  rptDst,
  input logic             overflow
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (rptValid && !rptReady) |=> rptValid); // R7

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (rptValid && !rptReady) |=> ($stable(rptMask) && $stable(rptSrc) && $stable(rptDst))); // R7

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rptValid |-> (rptMask != '0)); // R3

  AST_RISE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rptValid) |-> $past(flitValid && eop)); // R4

  AST_DROP_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> $past(rptValid && !rptReady && flitValid && eop)); // R8

  AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> (!overflow || $past(flitValid && eop))); // R8
endmodule

bind colErrMonitor colmon_checker #(.WIDTH(WIDTH), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .flitValid(flitValid),
  .eop      (eop),
  .rptValid (rptValid),
  .rptReady (rptReady),
  .rptMask  (rptMask),
  .rptSrc   (rptSrc),
  .rptDst   (rptDst),
  .overflow (overflow)
);

// File: tb/tb_colErrMonitor.sv
`timescale 1ns/1ps
module tb_colErrMonitor;
  localparam int W = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  thr = 4'd3;
  logic        flitValid = 1'b0, sop = 1'b0, eop = 1'b0;
  logic [W-1:0] errVec = '0;
  logic [7:0]  srcId = '0, dstId = '0;
  logic        rdy = 1'b1;
  logic        rptValid, overflow;
  logic [W-1:0] rptMask;
  logic [7:0]  rptSrc, rptDst;

  always #4 clk = ~clk;  // 125 MHz

  colErrMonitor dut (
    .clk(clk), .rstN(rstN), .threshold(thr), .flitValid(flitValid),
    .sop(sop), .eop(eop), .errVec(errVec), .srcId(srcId), .dstId(dstId),
    .rptValid(rptValid), .rptReady(rdy), .rptMask(rptMask),
    .rptSrc(rptSrc), .rptDst(rptDst), .overflow(overflow)
  );

  typedef struct {
    logic [W-1:0] mask;
    logic [7:0]   src;
    logic [7:0]   dst;
    string        tag;
  } exp_t;

  exp_t expQ[$];
  int   nTests = 0;
  int   nFail  = 0;
  int   ovfSeen = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compares every offered report against the queue head
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (overflow) ovfSeen++;
      if (rptValid) begin
        if (expQ.size() == 0) begin
          check(0, "R3", "unexpected report mask", rptMask, '0);
        end else begin
          check(rptMask == expQ[0].mask, expQ[0].tag, "mask", rptMask, expQ[0].mask);
          check({rptSrc, rptDst} == {expQ[0].src, expQ[0].dst}, "R4", "src/dst",
                {48'd0, rptSrc, rptDst}, {48'd0, expQ[0].src, expQ[0].dst});
          if (rdy) void'(expQ.pop_front());
        end
      end
    end
  end

  // driver with reference model
  task automatic sendPacket(input logic [7:0] s, input logic [7:0] d, input int nFlits,
                            input int col, input int hits, input bit noise,
                            input int gap, input bit drop, input string tag);
    int cnt[W];
    logic [W-1:0] v;
    exp_t e;
    for (int i = 0; i < W; i++) cnt[i] = 0;
    for (int f = 0; f < nFlits; f++) begin
      if (f > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(posedge clk); #1;
          flitValid = 0; sop = 1; eop = 1; errVec = '1;   // must be ignored (R11)
        end
      end
      v = '0;
      if (f < hits) v[col] = 1'b1;
      if (noise) v[(f * 7 + 3) % W] = 1'b1;
      for (int i = 0; i < W; i++)
        if (v[i] && cnt[i] < 15) cnt[i]++;
      @(posedge clk); #1;
      flitValid = 1; sop = (f == 0); eop = (f == nFlits - 1);
      errVec = v; srcId = s; dstId = d;
    end
    e.mask = '0;
    for (int i = 0; i < W; i++) e.mask[i] = (cnt[i] > int'(thr));
    e.src = s; e.dst = d; e.tag = tag;
    if (e.mask != '0 && !drop) expQ.push_back(e);
    @(posedge clk); #1;
    flitValid = 0; sop = 0; eop = 0; errVec = '0;
  endtask

  task automatic settle(input string tag);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, tag, "pending expected reports", W'(expQ.size()), '0);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check({rptValid, overflow} == 2'b00, "R1", "valid/overflow after reset",
          {62'd0, rptValid, overflow}, '0);

    // R2: 4 hits > 3 with scattered noise, idle gaps holding junk (R11)
    thr = 3;
    sendPacket(8'h12, 8'h34, 13, 12, 4, 1, 2, 0, "R2");
    settle("R2");

    // R2 boundary / R3: count equal to threshold, no report
    sendPacket(8'h21, 8'h43, 13, 12, 3, 1, 0, 0, "R3");
    repeat (3) @(negedge clk);
    check(rptValid == 0, "R3", "no report when count equals threshold", W'(rptValid), '0);

    // R9: same packet flagged under a lower threshold
    thr = 2;
    sendPacket(8'h22, 8'h44, 13, 12, 3, 1, 0, 0, "R9");
    settle("R9");

    // R5: counts from the previous packet must not carry over
    thr = 3;
    sendPacket(8'h01, 8'h02, 13, 40, 3, 0, 0, 0, "R5");
    sendPacket(8'h03, 8'h04, 13, 40, 1, 0, 0, 0, "R5");
    repeat (3) @(negedge clk);
    check(rptValid == 0, "R5", "no report after clear at sop", W'(rptValid), '0);

    // R6: saturation with 20 hits, threshold 14
    thr = 14;
    sendPacket(8'h55, 8'h66, 20, 5, 20, 0, 0, 0, "R6");
    settle("R6");

    // R10: single-flit packet, threshold 0
    thr = 0;
    sendPacket(8'h7a, 8'h7b, 1, 63, 1, 0, 0, 0, "R10");
    settle("R10");

    // R11: only ignored cycles carry errors, threshold 0
    sendPacket(8'h0c, 8'h0d, 4, 0, 0, 0, 3, 0, "R11");
    repeat (3) @(negedge clk);
    check(rptValid == 0, "R11", "idle cycles ignored", W'(rptValid), '0);

    // R7 / R8: stall, then a second flagged packet is dropped
    thr = 1;
    rdy = 0;
    sendPacket(8'hA1, 8'hB1, 13, 30, 5, 0, 0, 0, "R7");
    repeat (6) @(negedge clk);
    check(rptValid == 1, "R7", "report held while stalled", W'(rptValid), 64'd1);
    ovfSeen = 0;
    sendPacket(8'hA2, 8'hB2, 13, 31, 5, 0, 0, 1, "R8");
    repeat (3) @(negedge clk);
    check(ovfSeen == 1, "R8", "overflow pulse count", W'(ovfSeen), 64'd1);
    @(posedge clk); #1 rdy = 1;
    settle("R8");
    check(rptValid == 0, "R8", "dropped report never appears", W'(rptValid), '0);

    finishRun();
  end
endmodule